// File: doc/BRIEF.md
# Self-Timed Sector Write Controller

This block manages a small nonvolatile-style byte array organised in 128-byte sectors and held in on-chip registers. A client loads bytes one at a time, each with a full byte address. The first byte opens a sector. Further bytes for the same sector may follow in any order, and they gather in a page buffer. If no further byte arrives within a programmable number of clock cycles, loading closes on its own. The controller then runs a timed write cycle. In that cycle the whole target sector is first set to FFH, and the loaded bytes are then placed into it.

A separate request erases the whole array in a timed cycle. A ready flag is low while either timed cycle runs. A read during that time returns a status byte instead of array data. In the status byte, bit 7 is the inverse of bit 7 of the most recently loaded byte, and bit 6 flips on every read. This lets software detect completion either by polling the data or by watching the toggle bit. All time limits are parameters counted in clock cycles, so a simulation can use short windows.

Top module: `pw_flash_ctrl`

## Requirements
- R1: After synchronous reset, `ready` is 1 and `rd_data` is 00H.
- R2: Address bits [6:0] select the byte inside a sector and the bits above select the sector. Bytes of one sector may be loaded in any order and each lands at its own address.
- R3: The write cycle starts LOAD_WINDOW clock edges after the last accepted load. `ready` falls at that edge. Every accepted load restarts the window.
- R4: A write cycle sets every byte of the target sector that was not loaded to FFH, which replaces any earlier contents.
- R5: `ready` stays 0 for exactly WRITE_CYCLES cycles of a write cycle and then returns to 1, after which reads return the new data.
- R6: While a sector is being loaded, a load whose sector differs from the open one is ignored.
- R7: Loads that arrive while `ready` is 0 are ignored.
- R8: A read while `ready` is 0 returns a status byte. Its bit 7 is the complement of bit 7 of the last loaded byte (0 during chip erase), and its bits [5:0] are 0.
- R9: Bit 6 of the status byte is 0 on the first busy read of a cycle and alternates on each later busy read.
- R10: `erase_req` in idle starts a chip erase that keeps `ready` at 0 for exactly ERASE_CYCLES cycles and leaves every byte at FFH.
- R11: `erase_req` is acted on only in idle. It is ignored while a sector is loading or while busy. If it coincides with a load in idle, the erase wins and the load is dropped.
- R12: `rd_data` shows the result one clock edge after the cycle in which `rd_en` is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Byte-load request |
| ld_addr | input | ADDR_W | Byte address of the load (sector and offset) |
| ld_data | input | 8 | Byte to load |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address to read |
| rd_data | output | 8 | Read result or busy status |
| erase_req | input | 1 | Whole-array erase request |
| ready | output | 1 | 1 when no timed cycle is running |

## Verification
The bench builds the block with four sectors, a 16-cycle load window, 160-cycle write cycles and 600-cycle erase cycles. With these values the window boundary, the exact busy lengths and a complete sector write-back can all be checked cycle by cycle in a few thousand clocks. The 600-cycle erase still sweeps the full 512-byte array, which leaves no uncovered address range.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2,
    ST_ERASE = 2'd3
  } pwf_state_e;

  function automatic int pwf_max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/pwf_page_buf.sv
module pwf_page_buf #(
  parameter int SECTOR_BYTES = 128,
  localparam int OFF_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             clr_mask,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte,
  output logic             rd_loaded
);

  logic [7:0]              store [SECTOR_BYTES];
  logic [SECTOR_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_en) begin
      if (clr_mask) mask_q <= SECTOR_BYTES'(1) << wr_off;
      else          mask_q[wr_off] <= 1'b1;
    end
  end

  assign rd_byte   = store[rd_off];
  assign rd_loaded = mask_q[rd_off];

  // a newly opened sector starts with exactly one loaded byte
  assert_fresh_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && clr_mask) |=> ($countones(mask_q) == 1));

endmodule

// File: rtl/pwf_array.sv
module pwf_array #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 8'h00;
    else if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/pw_flash_ctrl.sv
module pw_flash_ctrl #(
  parameter int SECTOR_BYTES = 128,
  parameter int NUM_SECTORS  = 4,
  parameter int LOAD_WINDOW  = 3600,
  parameter int WRITE_CYCLES = 60000,
  parameter int ERASE_CYCLES = 60000,
  localparam int OFF_W  = $clog2(SECTOR_BYTES),
  localparam int SEC_W  = $clog2(NUM_SECTORS),
  localparam int ADDR_W = OFF_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              erase_req,
  output logic              ready
);
  import pwf_pkg::*;

  localparam int DEPTH = SECTOR_BYTES * NUM_SECTORS;
  localparam int MAXC  = pwf_max3(LOAD_WINDOW, WRITE_CYCLES, ERASE_CYCLES);
  localparam int CNT_W = $clog2(MAXC + 1);

  pwf_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEC_W-1:0]  sector_q;
  logic              last7_q, poll7_q, tog_q, ready_q, sel_q;
  logic [7:0]        status_q;

  logic [SEC_W-1:0]  ld_sec;
  logic [OFF_W-1:0]  ld_off;
  logic              busy, accept_first, accept_more, buf_we;
  logic [7:0]        buf_byte, arr_q, arr_wdata;
  logic              buf_loaded, arr_we;
  logic [ADDR_W-1:0] arr_waddr;

  assign ld_sec       = ld_addr[ADDR_W-1:OFF_W];
  assign ld_off       = ld_addr[OFF_W-1:0];
  assign busy         = (state_q == ST_PROG) || (state_q == ST_ERASE);
  assign accept_first = (state_q == ST_IDLE) && ld_valid && !erase_req;
  assign accept_more  = (state_q == ST_LOAD) && ld_valid && (ld_sec == sector_q);
  assign buf_we       = accept_first || accept_more;

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = '0;
    arr_wdata = 8'hFF;
    if (state_q == ST_PROG) begin
      arr_we    = cnt_q < CNT_W'(SECTOR_BYTES);
      arr_waddr = {sector_q, cnt_q[OFF_W-1:0]};
      arr_wdata = buf_loaded ? buf_byte : 8'hFF;
    end else if (state_q == ST_ERASE) begin
      arr_we    = cnt_q < CNT_W'(DEPTH);
      arr_waddr = cnt_q[ADDR_W-1:0];
    end
  end

  pwf_page_buf #(.SECTOR_BYTES(SECTOR_BYTES)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (buf_we),
    .clr_mask (accept_first),
    .wr_off   (ld_off),
    .wr_data  (ld_data),
    .rd_off   (cnt_q[OFF_W-1:0]),
    .rd_byte  (buf_byte),
    .rd_loaded(buf_loaded)
  );

  pwf_array #(.DEPTH(DEPTH)) u_arr (
    .clk  (clk),
    .rst  (rst),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .re   (rd_en && !busy),
    .raddr(rd_addr),
    .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sector_q <= '0;
      last7_q  <= 1'b0;
      poll7_q  <= 1'b0;
      tog_q    <= 1'b0;
      ready_q  <= 1'b1;
      sel_q    <= 1'b0;
      status_q <= 8'h00;
    end else begin
      if (rd_en) sel_q <= busy;
      if (rd_en && busy) begin
        status_q <= {poll7_q, tog_q, 6'b0};
        tog_q    <= ~tog_q;
      end
      case (state_q)
        ST_IDLE: begin
          if (erase_req) begin
            state_q <= ST_ERASE;
            cnt_q   <= '0;
            ready_q <= 1'b0;
            poll7_q <= 1'b0;
            tog_q   <= 1'b0;
          end else if (ld_valid) begin
            state_q  <= ST_LOAD;
            cnt_q    <= '0;
            sector_q <= ld_sec;
            last7_q  <= ld_data[7];
          end
        end
        ST_LOAD: begin
          if (accept_more) begin
            cnt_q   <= '0;
            last7_q <= ld_data[7];
          end else if (cnt_q == CNT_W'(LOAD_WINDOW - 1)) begin
            state_q <= ST_PROG;
            cnt_q   <= '0;
            ready_q <= 1'b0;
            poll7_q <= ~last7_q;
            tog_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ready_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CNT_W'(ERASE_CYCLES - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ready_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready   = ready_q;
  assign rd_data = sel_q ? status_q : arr_q;

  assert_ready_matches_R5: assert property (@(posedge clk) disable iff (rst)
    ready_q != busy);

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD) |-> (cnt_q < CNT_W'(LOAD_WINDOW)));

  assert_window_expiry_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && !ld_valid && cnt_q == CNT_W'(LOAD_WINDOW - 1))
      |=> (state_q == ST_PROG && !ready_q));

  assert_erase_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && erase_req) |=> (state_q != ST_ERASE));

  assert_busy_status_low_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_data[5:0] == 6'b0));

  assert_busy_sector_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_valid) |=> $stable(sector_q));

endmodule

// File: tb/pw_flash_ctrl_bench.sv
module pw_flash_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SB = 128;
  localparam int NS = 4;
  localparam int LW = 16;
  localparam int WC = 160;
  localparam int EC = 600;
  localparam int AW = 9;
  localparam int NVEC = 6;

  // {address, data}: sector 1, deliberately out of order; last byte has bit 7 = 0
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h0F0, 8'h81}, {9'h083, 8'h5A}, {9'h0FF, 8'h00},
    {9'h080, 8'hC3}, {9'h0C1, 8'h7E}, {9'h09A, 8'h26}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = 8'h00;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          erase_req = 1'b0;
  logic          ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pw_flash_ctrl #(
    .SECTOR_BYTES(SB), .NUM_SECTORS(NS), .LOAD_WINDOW(LW),
    .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)
  ) u_pw_flash_ctrl (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .erase_req(erase_req), .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (ready) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_all();
  end

  initial begin
    logic [7:0] d;
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 rd_data after reset", rd_data, 8'h00);

    // erase and a load in the same idle cycle: erase wins
    erase_req = 1'b1; ld_valid = 1'b1; ld_addr = 9'h000; ld_data = 8'h00;
    @(negedge clk);
    erase_req = 1'b0; ld_valid = 1'b0;
    chk("R11 erase started", ready, 0);
    wait_ready(n);
    chk("R10 erase busy length", n, EC);
    rd(9'h000, d); chk("R11 coincident load dropped", d, 8'hFF);
    rd(9'h1FF, d); chk("R10 top byte erased", d, 8'hFF);
    rd(9'h0C1, d); chk("R10 mid byte erased", d, 8'hFF);

    // table-driven sector load with a foreign-sector load mixed in
    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][16:8], VEC[i][7:0]);
      if (i == 2) load(9'h105, 8'h11);   // R6: other sector, ignored
    end
    repeat (LW - 1) @(negedge clk);
    chk("R3 still loading before window end", ready, 1);
    @(negedge clk);
    chk("R3 busy at window end", ready, 0);
    rd(9'h09A, d); chk("R8 R9 first busy read", d, 8'h80);
    rd(9'h0F0, d); chk("R9 second busy read toggles", d, 8'hC0);
    load(9'h183, 8'h44);                  // R7: ignored while busy
    wait_ready(n);
    chk("R5 write busy length", n, WC - 3);
    for (int i = 0; i < NVEC; i++) begin
      rd(VEC[i][16:8], d);
      chk("R2 loaded byte", d, VEC[i][7:0]);
    end
    rd(9'h0A0, d); chk("R4 unloaded byte is FF", d, 8'hFF);
    rd(9'h105, d); chk("R6 foreign sector untouched", d, 8'hFF);
    rd(9'h183, d); chk("R7 busy load ignored", d, 8'hFF);

    // read result holds between reads
    rd(9'h083, d);
    repeat (4) @(negedge clk);
    chk("R12 rd_data holds", rd_data, 8'h5A);

    // rewrite sector 1 with one byte: auto-erase clears old bytes
    load(9'h0A0, 8'h12);
    wait_busy(n);
    wait_ready(n);
    rd(9'h0F0, d); chk("R4 old byte replaced by FF", d, 8'hFF);
    rd(9'h0A0, d); chk("R4 new byte written", d, 8'h12);

    // window restart, erase request while loading ignored
    load(9'h010, 8'h55);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    repeat (LW - 3) @(negedge clk);
    load(9'h011, 8'hAA);
    @(negedge clk);
    chk("R3 R11 window restarted, no erase", ready, 1);
    wait_busy(n);
    chk("R3 window after restart", n, LW - 1);
    rd(9'h010, d); chk("R9 R8 toggle restarts per cycle", d, 8'h00);
    wait_ready(n);
    rd(9'h010, d); chk("R2 sector 0 byte 10", d, 8'h55);
    rd(9'h011, d); chk("R12 R2 sector 0 byte 11", d, 8'hAA);
    rd(9'h012, d); chk("R4 sector 0 byte 12", d, 8'hFF);
    rd(9'h0A0, d); chk("R11 sector 1 survived ignored erase", d, 8'h12);

    finish_all();
  end

endmodule